// File: doc/BRIEF.md
# External Bus Yield Controller

This block lets an outside master borrow a processor's external memory bus. The master pulls the active-low request line low. The controller first passes the request through a synchronizer. It then waits for a safe point: either no external access is under way, or the current access is in its final cycle. At that point it withdraws the processor's address, data and strobe drivers, drops the active-low grant, and normally freezes the execution pipeline. The grant may land between two external accesses of the same instruction, so an instruction does not have to finish before the bus is handed over.

When the run-on option (`go_mode`) is set at grant time, the pipeline keeps executing while the bus is lent. It stalls only when it reaches an instruction that needs the external bus. When the request is withdrawn, the drivers come back, the grant is removed and the pipeline carries on from where it stopped. A separate core-reset input tells the block that the processor is held in reset. The request is still honoured then, and no access is treated as pending.

The controller is a five-state machine:
- `ST_OWN`: the processor owns the bus.
- `ST_WAIT`: a request is pending while an access finishes.
- `ST_HALT`: the bus is lent and the pipeline is frozen.
- `ST_RUN`: the bus is lent and the pipeline runs on.
- `ST_STALL`: the bus is lent and a run-on core has reached an external access.

Transitions:
- `ST_OWN`→`ST_WAIT` on a request during a non-final access cycle.
- `ST_OWN` or `ST_WAIT`→`ST_HALT`/`ST_RUN` at a safe point, the choice made by `go_mode`.
- `ST_WAIT`→`ST_OWN` when the request is withdrawn before the access ends.
- `ST_RUN`→`ST_STALL` when `next_needs_bus` rises.
- Any lent state→`ST_OWN` when the request is withdrawn.

Top module: `bus_yield_ctrl`

## Requirements
- R1: While `rst_n` is low, and just after it is released, the outputs are `bgrant_n`=1, `drive_en`=1 and `core_halt`=0.
- R2: With no access in progress, the outputs change after the third rising edge that follows a fall of `breq_n`: `bgrant_n`=0, `drive_en`=0 and, with `go_mode`=0, `core_halt`=1. After only two edges they are unchanged.
- R3: An access with W wait states occupies W+1 cycles, with `xfer_busy`=1 and `xfer_last`=1 in the final cycle. If the request reaches the machine during such an access, the grant appears after the edge that ends the final cycle. That edge is the later of edge 3 and edge W+1, counting from the fall of `breq_n`.
- R4: Within a multi-access instruction, the grant is given at the end of the current access, even though `next_needs_bus`=1 announces a further access.
- R5: If `go_mode`=1 when the grant is made, `core_halt` stays 0 while lent. It goes to 1 in the same cycle that `next_needs_bus` is 1, and then stays 1 until release.
- R6: After `breq_n` rises, the outputs return to `bgrant_n`=1, `drive_en`=1, `core_halt`=0 after the third rising edge, and not before.
- R7: With `core_reset`=1, a request is granted at edge 3 even while `xfer_busy`=1 and `xfer_last`=0.
- R8: `drive_en` is 0 whenever `bgrant_n` is 0, and both change at the same edge.
- R9: With `breq_n` held high, the block never grants, whatever the access inputs do.
- R10: A request withdrawn while the machine waits for an access to end returns the block to `ST_OWN` without ever granting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller itself |
| breq_n | input | 1 | Active-low bus request from the external master (asynchronous) |
| core_reset | input | 1 | High while the processor core is held in reset |
| xfer_busy | input | 1 | An external access occupies this cycle |
| xfer_last | input | 1 | This cycle is the final cycle of the current access |
| next_needs_bus | input | 1 | The next step of the pipeline needs the external bus |
| go_mode | input | 1 | Keep executing while the bus is lent |
| bgrant_n | output | 1 | Active-low bus grant |
| drive_en | output | 1 | Enable for the address, data and strobe drivers (0 = high impedance) |
| core_halt | output | 1 | Freezes the execution pipeline |

## Verification
The bench sweeps the wait-state count from 0 to 7 and checks every cycle before and at the expected grant edge.

Several wrong designs are caught this way:
- A design that grants in the middle of an access shows the grant too early.
- A design that waits one cycle too long, or that ignores the synchronizer latency, shows it too late.
- A design that treats `next_needs_bus` as a reason to hold the grant fails the multi-access case.
- A run-on design that halts at grant time, or that misses the stall, fails the run-on case.
- A design that forgets the withdrawal while waiting grants a bus nobody asked for.
- A design that blocks the request during core reset never grants in that case.

// File: rtl/bus_yield_pkg.sv
package bus_yield_pkg;
    typedef enum logic [2:0] {
        ST_OWN   = 3'd0,
        ST_WAIT  = 3'd1,
        ST_HALT  = 3'd2,
        ST_RUN   = 3'd3,
        ST_STALL = 3'd4
    } yield_state_t;
endpackage

// File: rtl/req_sync.sv
module req_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/yield_fsm.sv
module yield_fsm
    import bus_yield_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic core_reset,
    input  logic xfer_busy,
    input  logic xfer_last,
    input  logic next_needs_bus,
    input  logic go_mode,
    output logic bgrant_n,
    output logic drive_en,
    output logic core_halt
);
    yield_state_t state_q, state_d;
    logic safe_point;
    logic lent;
    yield_state_t lend_target;

    // A safe point: no access pending, the final cycle of one, or core in reset
    assign safe_point  = core_reset || !xfer_busy || xfer_last;
    assign lend_target = go_mode ? ST_RUN : ST_HALT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OWN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OWN: begin
                if (req) state_d = safe_point ? lend_target : ST_WAIT;
            end
            ST_WAIT: begin
                if (!req)           state_d = ST_OWN;
                else if (safe_point) state_d = lend_target;
            end
            ST_RUN: begin
                if (!req)               state_d = ST_OWN;
                else if (next_needs_bus) state_d = ST_STALL;
            end
            ST_HALT, ST_STALL: begin
                if (!req) state_d = ST_OWN;
            end
            default: state_d = ST_OWN;
        endcase
    end

    always_comb begin
        lent      = (state_q == ST_HALT) || (state_q == ST_RUN) || (state_q == ST_STALL);
        bgrant_n  = !lent;
        drive_en  = !lent;
        core_halt = (state_q == ST_HALT) || (state_q == ST_STALL) ||
                    ((state_q == ST_RUN) && next_needs_bus);
    end

    // R2: an idle request is lent at the next edge
    assert_idle_lend_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OWN && req && !xfer_busy) |=> (bgrant_n == 1'b0));

    // R3: a request during a non-final access cycle must wait
    assert_no_mid_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OWN && req && xfer_busy && !xfer_last && !core_reset)
        |=> (state_q == ST_WAIT));

    // R5: run-on core stalls on its first external access
    assert_go_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && req && next_needs_bus) |=> (state_q == ST_STALL && core_halt));

    // R6: withdrawal while lent returns the bus
    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bgrant_n && !req) |=> (bgrant_n && drive_en));

    // R7: core reset does not block the request
    assert_reset_lend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OWN && req && core_reset) |=> (!bgrant_n));

    // R10: withdrawal while waiting never grants
    assert_wait_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !req) |=> (state_q == ST_OWN && bgrant_n));
endmodule

// File: rtl/bus_yield_ctrl.sv
module bus_yield_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic breq_n,
    input  logic core_reset,
    input  logic xfer_busy,
    input  logic xfer_last,
    input  logic next_needs_bus,
    input  logic go_mode,
    output logic bgrant_n,
    output logic drive_en,
    output logic core_halt
);
    logic breq_n_sync;
    logic req_active;

    req_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (breq_n),
        .sync_out (breq_n_sync)
    );

    assign req_active = !breq_n_sync;

    yield_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req            (req_active),
        .core_reset     (core_reset),
        .xfer_busy      (xfer_busy),
        .xfer_last      (xfer_last),
        .next_needs_bus (next_needs_bus),
        .go_mode        (go_mode),
        .bgrant_n       (bgrant_n),
        .drive_en       (drive_en),
        .core_halt      (core_halt)
    );

    // R8: drivers are off whenever the grant is active
    assert_grant_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bgrant_n) |-> $fell(drive_en));
endmodule

// File: tb/sim_bus_yield_ctrl.sv
`timescale 1ns/1ps
module sim_bus_yield_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic breq_n = 1'b1;
    logic core_reset = 1'b0;
    logic xfer_busy = 1'b0;
    logic xfer_last = 1'b0;
    logic next_needs_bus = 1'b0;
    logic go_mode = 1'b0;
    logic bgrant_n, drive_en, core_halt;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [2:0] OUT_OWN  = 3'b110;
    localparam logic [2:0] OUT_HALT = 3'b001;
    localparam logic [2:0] OUT_RUN  = 3'b000;

    always #10 clk = ~clk;   // 50 MHz

    bus_yield_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .breq_n(breq_n), .core_reset(core_reset),
        .xfer_busy(xfer_busy), .xfer_last(xfer_last), .next_needs_bus(next_needs_bus),
        .go_mode(go_mode), .bgrant_n(bgrant_n), .drive_en(drive_en), .core_halt(core_halt)
    );

    function automatic logic [2:0] outs();
        return {bgrant_n, drive_en, core_halt};
    endfunction

    task automatic check(input string rq, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b (bgrant_n,drive_en,core_halt)", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic release_bus(input string rq, input logic [2:0] lent_val);
        breq_n = 1'b1;
        xfer_busy = 1'b0; xfer_last = 1'b0; next_needs_bus = 1'b0;
        tick(); tick();
        check(rq, outs(), lent_val);
        tick();
        check(rq, outs(), OUT_OWN);
        go_mode = 1'b0; core_reset = 1'b0;
        tick();
    endtask

    // Request with an access of W wait states already running (W<0: no access)
    task automatic t_access(input int w, input logic nb, input string rq);
        int e;
        e = (w + 1 > 3) ? w + 1 : 3;
        @(negedge clk);
        breq_n = 1'b0;
        xfer_busy = (w >= 0);
        xfer_last = (w == 0);
        next_needs_bus = nb;
        for (int k = 1; k <= e; k++) begin
            tick();
            check(rq, outs(), (k >= e) ? OUT_HALT : OUT_OWN);
            xfer_busy = (k + 1 <= w + 1) && (k < e);
            xfer_last = (k + 1 == w + 1) && (k < e);
        end
        release_bus("R6", OUT_HALT);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        check("R1", outs(), OUT_OWN);
        rst_n = 1'b1;
        tick();
        check("R1", outs(), OUT_OWN);
    endtask

    task automatic t_go();
        @(negedge clk);
        go_mode = 1'b1;
        breq_n = 1'b0;
        tick(); tick();
        check("R5", outs(), OUT_OWN);
        tick();
        check("R5", outs(), OUT_RUN);
        tick(); tick();
        check("R5", outs(), OUT_RUN);
        next_needs_bus = 1'b1;
        #1;
        check("R5", outs(), OUT_HALT);
        tick();
        next_needs_bus = 1'b0;
        #1;
        check("R5", outs(), OUT_HALT);
        release_bus("R6", OUT_HALT);
    endtask

    task automatic t_core_reset();
        @(negedge clk);
        core_reset = 1'b1;
        xfer_busy = 1'b1;
        xfer_last = 1'b0;
        breq_n = 1'b0;
        tick(); tick();
        check("R7", outs(), OUT_OWN);
        tick();
        check("R7", outs(), OUT_HALT);
        release_bus("R7", OUT_HALT);
    endtask

    task automatic t_unused();
        @(negedge clk);
        breq_n = 1'b1;
        for (int k = 0; k < 20; k++) begin
            xfer_busy = k[0];
            xfer_last = k[1];
            core_reset = (k == 7);
            tick();
            check("R9", outs(), OUT_OWN);
        end
        xfer_busy = 1'b0; xfer_last = 1'b0; core_reset = 1'b0;
    endtask

    task automatic t_abort();
        @(negedge clk);
        xfer_busy = 1'b1;
        xfer_last = 1'b0;
        breq_n = 1'b0;
        repeat (4) tick();
        check("R10", outs(), OUT_OWN);
        breq_n = 1'b1;
        repeat (3) tick();
        xfer_last = 1'b1;
        tick();
        xfer_busy = 1'b0;
        xfer_last = 1'b0;
        for (int k = 0; k < 6; k++) begin
            tick();
            check("R10", outs(), OUT_OWN);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        t_reset();
        t_access(-1, 1'b0, "R2");
        for (int w = 0; w < 8; w++) t_access(w, 1'b0, "R3");
        t_access(3, 1'b1, "R4");
        t_go();
        t_core_reset();
        t_unused();
        t_abort();
        finish_run();
    end

    // R8: sampled on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done && (bgrant_n == 1'b0) && (drive_en !== 1'b0)) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 actual drive_en=%b expected=0", drive_en);
        end
    end
endmodule